// File: doc/BRIEF.md
# Windowed Register File with Rotating Frames

This block is the register file of a small RISC core. It keeps a fixed pool of physical registers and arranges them as a ring of eight frames. The core always addresses 32 logical registers. Eight of them are globals that look the same from every frame. The other 24 are the incoming-argument, local and outgoing-argument registers of the current frame. A current-frame pointer turns each logical number into a physical location. The outgoing-argument group of one frame is the same storage as the incoming-argument group of the next frame. A call therefore only moves the pointer: the callee finds its arguments already in place, and no data is copied.

The core pulses `call_req` or `ret_req` to move the frame pointer. A second pointer, the boundary pointer, marks the most recently saved frame. When a call would run into that boundary, the block holds the request and raises an overflow trap. When a return would land on it, the block raises an underflow trap. While a trap is pending, an external agent reads or writes the incoming-argument and local registers of the named frame through a small save/restore port. It then pulses `trap_ack`. On that acknowledge the held call or return completes and the boundary pointer moves by one. The memory side of saving and restoring belongs to the agent.

Top module: `winreg_file`

## Requirements
- R1: Logical registers 0 to 7 are globals that map to the same storage from every frame. Logical 8 to 15 are the frame's outgoing arguments, 16 to 23 its locals and 24 to 31 its incoming arguments.
- R2: Logical register 0 always reads as zero, and a write to it has no effect.
- R3: A value written to outgoing-argument register 8+i in frame k reads back as incoming-argument register 24+i in frame k+1 (mod 8).
- R4: An accepted call sets `cur_win` to cur_win+1 mod 8, and an accepted return sets it to cur_win-1 mod 8. Both take effect at the next clock edge. A caller's locals read back unchanged after a call and the matching return.
- R5: After synchronous reset, `cur_win` is 0, `bnd_win` is 7, and neither trap flag is set.
- R6: A call with cur_win+1 mod 8 equal to `bnd_win` does not move `cur_win`. It sets `trap_ovf` at the next edge, and `trap_win` then shows bnd_win+1 mod 8 (the oldest resident frame, which must be saved).
- R7: A return with cur_win-1 mod 8 equal to `bnd_win` does not move `cur_win`. It sets `trap_unf` at the next edge, and `trap_win` then shows `bnd_win` (the frame that must be restored).
- R8: While a trap is pending, `call_req`, `ret_req` and the core write port have no effect. The save/restore port reaches frame `trap_win`: index 0 to 7 selects its incoming arguments and 8 to 15 its locals. Reads are combinational and writes take effect at the clock edge.
- R9: On `trap_ack` during an overflow, `bnd_win` and `cur_win` both advance by one. During an underflow, both retreat by one. In both cases the trap clears at the same edge and `cur_win` equals the old `bnd_win`.
- R10: A write and a read of the same physical register in the same cycle return the written value on the read port (write-first).
- R11: A cycle with both `call_req` and `ret_req` high leaves both pointers and both trap flags unchanged.
- R12: The pointers wrap: a call from frame 7 goes to frame 0, and the outgoing arguments of frame 7 are the incoming arguments of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Move to the next frame |
| ret_req | input | 1 | Move back to the previous frame |
| rd0_addr | input | 5 | Logical address, read port 0 |
| rd0_data | output | 32 | Read data, port 0 (combinational) |
| rd1_addr | input | 5 | Logical address, read port 1 |
| rd1_data | output | 32 | Read data, port 1 (combinational) |
| wr_en | input | 1 | Core write enable |
| wr_addr | input | 5 | Logical address of the core write |
| wr_data | input | 32 | Core write data |
| cur_win | output | 3 | Current frame pointer |
| bnd_win | output | 3 | Boundary (most recently saved) frame pointer |
| trap_ovf | output | 1 | Overflow trap pending |
| trap_unf | output | 1 | Underflow trap pending |
| trap_win | output | 3 | Frame to save or restore |
| sf_idx | input | 4 | Save/restore register index in frame `trap_win` |
| sf_we | input | 1 | Save/restore write enable |
| sf_wdata | input | 32 | Save/restore write data |
| sf_rdata | output | 32 | Save/restore read data |
| trap_ack | input | 1 | Agent has finished the save or restore |

## Verification
The bench walks the call depth all the way to the boundary and back. It checks the overflow at depth six and the wrapped overflow from frame 7 to frame 0. It also checks two underflows in a row. A design that tested the boundary one frame late would let a callee's outgoing arguments overwrite the oldest frame's arguments without any trap. The bench checks the argument overlap across the ring seam (frame 7 into frame 0). A translation that forgets the modulo would send those accesses past the end of the storage. It issues calls and core writes during a pending trap, then reads the frame that was targeted. A design that did not stall would move the pointer or corrupt that frame. Same-cycle write and read, and register 0, are checked at the read ports.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    // Default geometry of the windowed file.
    parameter int NWIN_D  = 8;   // frames in the ring
    parameter int NGLOB_D = 8;   // global registers
    parameter int GRP_D   = 8;   // registers per group (in/local/out)
    parameter int DW_D    = 32;  // data width

    // Pending trap kind held by the pointer controller.
    typedef enum logic [1:0] {
        TR_NONE  = 2'd0,
        TR_SPILL = 2'd1,
        TR_FILL  = 2'd2
    } trap_e;

    // Controller pointer pair.
    typedef struct packed {
        logic [2:0] cur;
        logic [2:0] bnd;
    } ptr_view_t;

    function automatic int wrap_inc(int v, int n);
        return (v + 1) % n;
    endfunction

    function automatic int wrap_dec(int v, int n);
        return (v + n - 1) % n;
    endfunction

    // First physical slot owned by frame w: incoming args, then locals.
    function automatic int frame_base(int w, int nglob, int grp);
        return nglob + w * 2 * grp;
    endfunction

endpackage

// File: rtl/winreg_xlate.sv
module winreg_xlate
    import winreg_pkg::*;
#(
    parameter int NWIN  = NWIN_D,
    parameter int NGLOB = NGLOB_D,
    parameter int GRP   = GRP_D,
    parameter int LW    = 5,
    parameter int WW    = 3,
    parameter int PW    = 8
) (
    input  logic [LW-1:0] laddr,
    input  logic [WW-1:0] win,
    output logic [PW-1:0] paddr
);

    localparam int OUT_LO = NGLOB;
    localparam int LOC_LO = NGLOB + GRP;
    localparam int IN_LO  = NGLOB + 2 * GRP;

    always_comb begin
        int l;
        int w;
        int slot;
        l = int'(laddr);
        w = int'(win);
        if (l < OUT_LO) begin
            slot = l;
        end else if (l < LOC_LO) begin
            // outgoing args live in the next frame's incoming-arg group
            slot = frame_base(wrap_inc(w, NWIN), NGLOB, GRP) + (l - OUT_LO);
        end else if (l < IN_LO) begin
            slot = frame_base(w, NGLOB, GRP) + GRP + (l - LOC_LO);
        end else begin
            slot = frame_base(w, NGLOB, GRP) + (l - IN_LO);
        end
        paddr = PW'(slot);
    end

endmodule

// File: rtl/winreg_store.sv
module winreg_store
    import winreg_pkg::*;
#(
    parameter int PHYS = 136,
    parameter int PW   = 8,
    parameter int DW   = DW_D,
    parameter int NRD  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [PW-1:0]           wa,
    input  logic [DW-1:0]           wd,
    input  logic [NRD-1:0][PW-1:0]  ra,
    output logic [NRD-1:0][DW-1:0]  rd
);

    logic [DW-1:0] mem [PHYS];

    // Physical slot 0 is the hard-wired zero global.
    always_ff @(posedge clk) begin
        if (we && wa != '0) begin
            mem[wa] <= wd;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NRD; g++) begin : g_rd
            logic hit;
            assign hit   = we && (wa == ra[g]);
            assign rd[g] = (ra[g] == '0) ? '0 :
                           hit           ? wd : mem[ra[g]];
        end
    endgenerate

    // R10: a committed write is found in storage on the following cycle
    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> mem[$past(wa)] == $past(wd));

endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int NWIN = NWIN_D,
    parameter int WW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic          trap_ack,
    output logic [WW-1:0] cur_win,
    output logic [WW-1:0] bnd_win,
    output trap_e         trap_kind,
    output logic [WW-1:0] trap_win
);

    trap_e         state;
    logic [WW-1:0] cwp_q, bwp_q;
    logic [WW-1:0] cwp_inc, cwp_dec, bwp_inc, bwp_dec;
    logic          do_call, do_ret;

    assign cwp_inc = WW'(wrap_inc(int'(cwp_q), NWIN));
    assign cwp_dec = WW'(wrap_dec(int'(cwp_q), NWIN));
    assign bwp_inc = WW'(wrap_inc(int'(bwp_q), NWIN));
    assign bwp_dec = WW'(wrap_dec(int'(bwp_q), NWIN));

    // Simultaneous call and return cancel each other.
    assign do_call = (state == TR_NONE) && call_req && !ret_req;
    assign do_ret  = (state == TR_NONE) && ret_req && !call_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q <= '0;
            bwp_q <= WW'(NWIN - 1);
            state <= TR_NONE;
        end else begin
            case (state)
                TR_NONE: begin
                    if (do_call) begin
                        if (cwp_inc == bwp_q) state <= TR_SPILL;
                        else                  cwp_q <= cwp_inc;
                    end else if (do_ret) begin
                        if (cwp_dec == bwp_q) state <= TR_FILL;
                        else                  cwp_q <= cwp_dec;
                    end
                end
                TR_SPILL: begin
                    if (trap_ack) begin
                        bwp_q <= bwp_inc;
                        cwp_q <= cwp_inc;
                        state <= TR_NONE;
                    end
                end
                TR_FILL: begin
                    if (trap_ack) begin
                        bwp_q <= bwp_dec;
                        cwp_q <= cwp_dec;
                        state <= TR_NONE;
                    end
                end
                default: state <= TR_NONE;
            endcase
        end
    end

    always_comb begin
        case (state)
            TR_SPILL: trap_win = bwp_inc;
            TR_FILL:  trap_win = bwp_q;
            default:  trap_win = '0;
        endcase
    end

    assign cur_win   = cwp_q;
    assign bnd_win   = bwp_q;
    assign trap_kind = state;

    // R9: the current frame never sits on the saved boundary
    a_r9_ptrs_distinct: assert property (@(posedge clk) disable iff (rst)
        cwp_q != bwp_q);

    // R8: pointers frozen while a trap waits for its acknowledge
    a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (state != TR_NONE && !trap_ack) |=> ($stable(cwp_q) && $stable(bwp_q)));

    // R4: an accepted call moves one frame forward
    a_r4_call_step: assert property (@(posedge clk) disable iff (rst)
        (do_call && cwp_inc != bwp_q) |=>
            cwp_q == WW'(wrap_inc(int'($past(cwp_q)), NWIN)));

    // R6: a call into the boundary traps and leaves the frame pointer alone
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (do_call && cwp_inc == bwp_q) |=> (state == TR_SPILL && $stable(cwp_q)));

    // R7: a return onto the boundary traps and leaves the frame pointer alone
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (do_ret && cwp_dec == bwp_q) |=> (state == TR_FILL && $stable(cwp_q)));

    // R9: after an acknowledge the frame pointer lands on the old boundary
    a_r9_ack_lands: assert property (@(posedge clk) disable iff (rst)
        (state != TR_NONE && trap_ack) |=> (cwp_q == $past(bwp_q) && state == TR_NONE));

    // R11: opposing requests in one cycle do nothing
    a_r11_both_noop: assert property (@(posedge clk) disable iff (rst)
        (state == TR_NONE && call_req && ret_req) |=>
            ($stable(cwp_q) && $stable(bwp_q) && state == TR_NONE));

endmodule

// File: rtl/winreg_file.sv
module winreg_file
    import winreg_pkg::*;
#(
    parameter int NWIN  = NWIN_D,
    parameter int NGLOB = NGLOB_D,
    parameter int GRP   = GRP_D,
    parameter int DW    = DW_D,
    localparam int NLOG = NGLOB + 3 * GRP,
    localparam int LW   = $clog2(NLOG),
    localparam int WW   = $clog2(NWIN),
    localparam int PHYS = NGLOB + NWIN * 2 * GRP,
    localparam int PW   = $clog2(PHYS),
    localparam int SW   = $clog2(2 * GRP)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic [LW-1:0] rd0_addr,
    output logic [DW-1:0] rd0_data,
    input  logic [LW-1:0] rd1_addr,
    output logic [DW-1:0] rd1_data,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [WW-1:0] cur_win,
    output logic [WW-1:0] bnd_win,
    output logic          trap_ovf,
    output logic          trap_unf,
    output logic [WW-1:0] trap_win,
    input  logic [SW-1:0] sf_idx,
    input  logic          sf_we,
    input  logic [DW-1:0] sf_wdata,
    output logic [DW-1:0] sf_rdata,
    input  logic          trap_ack
);

    localparam int NRD = 3;

    trap_e                  trap_kind;
    logic                   stalled;
    logic [LW-1:0]          log_addr [NRD];
    logic [NRD-1:0][PW-1:0] rd_phys;
    logic [NRD-1:0][DW-1:0] rd_val;
    logic [PW-1:0]          core_wphys;
    logic [PW-1:0]          sf_phys;
    logic                   st_we;
    logic [PW-1:0]          st_wa;
    logic [DW-1:0]          st_wd;

    winreg_ctrl #(.NWIN(NWIN), .WW(WW)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .call_req  (call_req),
        .ret_req   (ret_req),
        .trap_ack  (trap_ack),
        .cur_win   (cur_win),
        .bnd_win   (bnd_win),
        .trap_kind (trap_kind),
        .trap_win  (trap_win)
    );

    assign stalled  = (trap_kind != TR_NONE);
    assign trap_ovf = (trap_kind == TR_SPILL);
    assign trap_unf = (trap_kind == TR_FILL);

    // Two core read ports translated through the current frame.
    assign log_addr[0] = rd0_addr;
    assign log_addr[1] = rd1_addr;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_xr
            winreg_xlate #(
                .NWIN(NWIN), .NGLOB(NGLOB), .GRP(GRP),
                .LW(LW), .WW(WW), .PW(PW)
            ) xr_i (
                .laddr (log_addr[g]),
                .win   (cur_win),
                .paddr (rd_phys[g])
            );
        end
    endgenerate

    winreg_xlate #(
        .NWIN(NWIN), .NGLOB(NGLOB), .GRP(GRP),
        .LW(LW), .WW(WW), .PW(PW)
    ) xw_i (
        .laddr (wr_addr),
        .win   (cur_win),
        .paddr (core_wphys)
    );

    // Save/restore port addresses the trapped frame directly.
    assign sf_phys    = PW'(frame_base(int'(trap_win), NGLOB, GRP) + int'(sf_idx));
    assign rd_phys[2] = sf_phys;
    assign log_addr[2] = '0;

    // The single write port belongs to the agent while a trap is pending.
    always_comb begin
        if (stalled) begin
            st_we = sf_we;
            st_wa = sf_phys;
            st_wd = sf_wdata;
        end else begin
            st_we = wr_en;
            st_wa = core_wphys;
            st_wd = wr_data;
        end
    end

    winreg_store #(.PHYS(PHYS), .PW(PW), .DW(DW), .NRD(NRD)) store_i (
        .clk (clk),
        .rst (rst),
        .we  (st_we),
        .wa  (st_wa),
        .wd  (st_wd),
        .ra  (rd_phys),
        .rd  (rd_val)
    );

    assign rd0_data = rd_val[0];
    assign rd1_data = rd_val[1];
    assign sf_rdata = rd_val[2];

    // R2: logical register 0 reads zero on both core ports
    a_r2_r0_zero: assert property (@(posedge clk) disable iff (rst)
        (rd0_addr == '0) |-> (rd0_data == '0 && (rd1_addr != '0 || rd1_data == '0)));

    // R6, R7: at most one trap kind is pending
    a_r6_one_trap: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trap_ovf, trap_unf}));

    // R8: the core cannot write storage while a trap is pending
    a_r8_core_blocked: assert property (@(posedge clk) disable iff (rst)
        (stalled && !sf_we) |-> !st_we);

endmodule

// File: tb/winreg_file_tb_top.sv
module winreg_file_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        call_req, ret_req, wr_en, sf_we, trap_ack;
    logic [4:0]  rd0_addr, rd1_addr, wr_addr;
    logic [31:0] rd0_data, rd1_data, wr_data, sf_wdata, sf_rdata;
    logic [2:0]  cur_win, bnd_win, trap_win;
    logic        trap_ovf, trap_unf;
    logic [3:0]  sf_idx;

    always #10 clk = ~clk;   // 50 MHz

    winreg_file dut_i (
        .clk(clk), .rst(rst), .call_req(call_req), .ret_req(ret_req),
        .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cur_win(cur_win), .bnd_win(bnd_win),
        .trap_ovf(trap_ovf), .trap_unf(trap_unf), .trap_win(trap_win),
        .sf_idx(sf_idx), .sf_we(sf_we), .sf_wdata(sf_wdata),
        .sf_rdata(sf_rdata), .trap_ack(trap_ack)
    );

    localparam int S_RD0 = 0, S_RD1 = 1, S_CWP = 2, S_BWP = 3,
                   S_OVF = 4, S_UNF = 5, S_TWIN = 6, S_SF = 7;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    task automatic expect_val(int sel, logic [31:0] exp, string tag);
        item_t it;
        it.sel = sel;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares queued expectations mid-cycle.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t       it;
            logic [31:0] got;
            it = sb.pop_front();
            case (it.sel)
                S_RD0:   got = rd0_data;
                S_RD1:   got = rd1_data;
                S_CWP:   got = 32'(cur_win);
                S_BWP:   got = 32'(bnd_win);
                S_OVF:   got = 32'(trap_ovf);
                S_UNF:   got = 32'(trap_unf);
                S_TWIN:  got = 32'(trap_win);
                default: got = sf_rdata;
            endcase
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, got, it.exp);
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
        call_req = 0; ret_req = 0; wr_en = 0; sf_we = 0; trap_ack = 0;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        wr_addr = a; wr_data = d; wr_en = 1; cyc();
    endtask

    task automatic rd(logic [4:0] a, logic [31:0] e, string tag);
        rd0_addr = a; expect_val(S_RD0, e, tag); cyc();
    endtask

    task automatic rd_b(logic [4:0] a, logic [31:0] e, string tag);
        rd1_addr = a; expect_val(S_RD1, e, tag); cyc();
    endtask

    task automatic do_call();
        call_req = 1; cyc();
    endtask

    task automatic do_ret();
        ret_req = 1; cyc();
    endtask

    task automatic ptrs(int c, int b, string tag);
        expect_val(S_CWP, 32'(c), tag);
        expect_val(S_BWP, 32'(b), tag);
    endtask

    task automatic flags(int o, int u, string tag);
        expect_val(S_OVF, 32'(o), tag);
        expect_val(S_UNF, 32'(u), tag);
    endtask

    localparam logic [31:0] GA = 32'hA0A0_0003, L0 = 32'h0000_1000,
                            T0 = 32'h0000_2222, L1 = 32'h0000_1001,
                            W6 = 32'h0000_6666, SV = 32'h0000_5555,
                            QV = 32'h0000_7777, FV = 32'h0000_F111;

    initial begin
        rst = 1; call_req = 0; ret_req = 0; wr_en = 0; sf_we = 0; trap_ack = 0;
        rd0_addr = 0; rd1_addr = 0; wr_addr = 0; wr_data = 0;
        sf_idx = 0; sf_wdata = 0;
        repeat (3) cyc();
        rst = 0;
        // R5 reset state
        ptrs(0, 7, "R5"); flags(0, 0, "R5");
        cyc();
        // R2 register 0
        wr(5'd0, 32'h123);
        rd(5'd0, 32'h0, "R2");
        // set up frame 0
        wr(5'd3, GA);
        wr(5'd16, L0);
        wr(5'd8, T0);
        // R3/R1 after a call
        do_call();
        ptrs(1, 7, "R4 call");
        rd(5'd24, T0, "R3 out-to-in overlap");
        rd_b(5'd3, GA, "R1 global shared");
        wr(5'd16, L1);
        do_ret();
        ptrs(0, 7, "R4 return");
        rd(5'd16, L0, "R4 caller local kept");
        // R11 opposing requests
        call_req = 1; ret_req = 1; cyc();
        ptrs(0, 7, "R11"); flags(0, 0, "R11");
        cyc();
        // R10 write-first
        wr_addr = 5'd17; wr_data = 32'hBEEF; wr_en = 1;
        rd0_addr = 5'd17; expect_val(S_RD0, 32'hBEEF, "R10 bypass");
        cyc();
        rd(5'd17, 32'hBEEF, "R10 stored");
        // depth to frame 6
        for (int i = 0; i < 6; i++) do_call();
        ptrs(6, 7, "R4 depth");
        wr(5'd16, W6);
        // R6 overflow
        do_call();
        flags(1, 0, "R6"); ptrs(6, 7, "R6");
        expect_val(S_TWIN, 32'd0, "R6 trap frame");
        cyc();
        // R8 requests and core write ignored during trap
        call_req = 1; wr_addr = 5'd16; wr_data = 32'hDEAD; wr_en = 1;
        cyc();
        ptrs(6, 7, "R8 stalled");
        sf_idx = 4'd8; expect_val(S_SF, L0, "R8 save port read");
        cyc();
        sf_idx = 4'd8; sf_wdata = SV; sf_we = 1; cyc();
        trap_ack = 1; cyc();
        ptrs(7, 0, "R9 spill ack"); flags(0, 0, "R9 spill ack");
        cyc();
        // R12 wrap
        wr(5'd8, QV);
        do_call();
        flags(1, 0, "R12 wrapped overflow");
        expect_val(S_TWIN, 32'd1, "R6 trap frame 1");
        cyc();
        trap_ack = 1; cyc();
        ptrs(0, 1, "R12 wrap to 0");
        rd(5'd24, QV, "R12 seam overlap");
        rd(5'd16, SV, "R8 save port write");
        // unwind
        do_ret();
        ptrs(7, 1, "R12 wrap back");
        do_ret();
        rd(5'd16, W6, "R8 core write blocked");
        for (int i = 0; i < 4; i++) do_ret();
        ptrs(2, 1, "R4 unwind");
        // R7 underflow
        do_ret();
        flags(0, 1, "R7"); ptrs(2, 1, "R7");
        expect_val(S_TWIN, 32'd1, "R7 trap frame");
        cyc();
        sf_idx = 4'd8; sf_wdata = FV; sf_we = 1; cyc();
        trap_ack = 1; cyc();
        ptrs(1, 0, "R9 fill ack"); flags(0, 0, "R9 fill ack");
        rd(5'd16, FV, "R9 restored local");
        do_ret();
        flags(0, 1, "R7 second");
        expect_val(S_TWIN, 32'd0, "R7 trap frame 0");
        cyc();
        trap_ack = 1; cyc();
        ptrs(0, 7, "R9 second fill");
        cyc();
        cyc();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule